// File: doc/BRIEF.md
# Configurable Display-Identification I2C Slave

This block is an I2C slave that lets a host read and write display identification data kept in on-chip RAM. A three-bit configuration code selects which device address pairs the slave answers. Each recognised pair maps to its own region of RAM, and that region is either 128 or 256 bytes long. Bytes move between the bus and RAM through a small DMA engine. The engine takes the memory from the CPU for two clock cycles per byte.

SCL and SDA are oversampled by the system clock. SDA is driven only through an open-drain enable. A write transfer carries a one-byte offset first, followed by data bytes that land at consecutive locations. A read transfer returns bytes from consecutive locations, starting at the current offset. The offset is one register shared by all regions. It survives STOP and repeated START, and it is masked to the size of the region being accessed.

Top module: `edid_i2c_slave`

## Requirements
- R1: The configuration code selects which address bytes are acknowledged (seven-bit addresses 50h, 51h and 53h, i.e. bytes A0h/A1h, A2h/A3h, A6h/A7h). Code 000 or 100 accepts 50h only. Code 001 accepts 51h only. Code 010 or 110 accepts 50h and 51h. Code 011 accepts 53h only. Codes 101 and 111 accept none.
- R2: An address byte that is not accepted gets no ACK. SDA then stays released, including during ACK slots, until the next START.
- R3: In a write transfer the first data byte sets the offset. Each later byte is written to RAM at region base plus offset, and the offset then advances by one.
- R4: In a read transfer each byte is fetched from region base plus offset, and the offset then advances. The byte is sent MSB first, and the next byte is fetched after each master ACK.
- R5: The offset wraps at the region size: 128 for address 50h and 256 for 51h and 53h. An offset byte is masked to that size.
- R6: Each byte moved to or from RAM holds `cpu_stall` high for exactly two consecutive cycles. `mem_en` is high in the first of the two, and read data is taken in the second.
- R7: A master NACK after a read byte ends the transfer. SDA stays released until the next START.
- R8: A repeated START returns the slave to address reception and keeps the current offset.
- R9: The configuration code is taken only while `en` is low. Changes made while `en` is high have no effect.
- R10: While `en` is low the slave never drives SDA and does not respond to the bus.
- R11: Region bases in the RAM address are 000h for 50h, 100h for 51h and 200h for 53h. The region index occupies `mem_addr[9:8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Slave enable; configuration is loaded while low |
| cfg | input | 3 | Address-set configuration code |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| cpu_stall | output | 1 | CPU memory access held off |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write when high, read when low |
| mem_addr | output | 10 | RAM byte address (region index and offset) |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid the cycle after `mem_en` |

## Verification
A reference model in the bench tracks the expected RAM access sequence and the shared offset, and it checks every clock for stall-run length and for each memory access. The configuration code is swept through all eight values, and each code is probed with all three address pairs, which separates the acknowledge table from the region mapping. Writes and reads are placed at offsets next to the 128- and 256-byte ends, and offset bytes above 127 are sent to the small region, which tells wrap and masking apart from plain incrementing. Several more patterns are used: reads entered through a repeated START after an offset-only write, reads that continue after a STOP, a code change while enabled, and clocking after a NACK or a rejected address. These separate offset retention, the configuration load gate and the released-bus states.

// File: rtl/edid_pkg.sv
package edid_pkg;
  localparam int OFF_W  = 8;
  localparam int RG_W   = 2;
  localparam int ADDR_W = RG_W + OFF_W;

  localparam logic [6:0] DEV_V1  = 7'h50;
  localparam logic [6:0] DEV_V2A = 7'h51;
  localparam logic [6:0] DEV_V2B = 7'h53;

  typedef enum logic [RG_W-1:0] {
    RG_V1  = 2'd0,
    RG_V2A = 2'd1,
    RG_V2B = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } bus_st_e;

  function automatic logic [OFF_W-1:0] off_mask(region_e r);
    return (r == RG_V1) ? 8'h7F : 8'hFF;
  endfunction
endpackage

// File: rtl/edid_bus_sync.sv
module edid_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/edid_addr_decode.sv
module edid_addr_decode
  import edid_pkg::*;
(
  input  logic [2:0] cfg,
  input  logic [6:0] dev,
  output logic       hit,
  output region_e    region
);
  logic allow_v1, allow_v2a, allow_v2b;

  always_comb begin
    allow_v1  = 1'b0;
    allow_v2a = 1'b0;
    allow_v2b = 1'b0;
    case (cfg)
      3'b000, 3'b100: allow_v1 = 1'b1;
      3'b001:         allow_v2a = 1'b1;
      3'b010, 3'b110: begin
        allow_v1  = 1'b1;
        allow_v2a = 1'b1;
      end
      3'b011:         allow_v2b = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    hit    = 1'b0;
    region = RG_V1;
    if (allow_v1 && dev == DEV_V1) begin
      hit = 1'b1;
      region = RG_V1;
    end else if (allow_v2a && dev == DEV_V2A) begin
      hit = 1'b1;
      region = RG_V2A;
    end else if (allow_v2b && dev == DEV_V2B) begin
      hit = 1'b1;
      region = RG_V2B;
    end
  end
endmodule

// File: rtl/edid_dma.sv
module edid_dma #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic [DW-1:0] rd_data,
  output logic          cpu_stall,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  typedef enum logic [1:0] {D_IDLE, D_ISSUE, D_TAKE} dma_st_e;

  dma_st_e       st_q, st_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      D_IDLE:  if (go) st_d = D_ISSUE;
      D_ISSUE: st_d = D_TAKE;
      default: st_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= D_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == D_IDLE && go) begin
        we_q   <= go_we;
        addr_q <= go_addr;
        wd_q   <= go_wdata;
      end
      if (st_q == D_TAKE && !we_q) rd_q <= mem_rdata;
    end
  end

  assign cpu_stall = (st_q != D_IDLE);
  assign mem_en    = (st_q == D_ISSUE);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rd_data   = rd_q;
endmodule

// File: rtl/edid_i2c_slave.sv
module edid_i2c_slave
  import edid_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        cfg,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              cpu_stall,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  edid_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic [2:0] cfg_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)  cfg_q <= '0;
    else if (!en)  cfg_q <= cfg;
  end

  bus_st_e          st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [6:0]       sh_q, sh_d;
  logic [6:0]       tx_q, tx_d;
  logic [OFF_W-1:0] off_q, off_d;
  region_e          rg_q, rg_d;
  logic             rw_q, rw_d;
  logic             fw_q, fw_d;
  logic             oe_q, oe_d;

  logic             hit;
  region_e          hit_rg;

  edid_addr_decode u_dec (.cfg(cfg_q), .dev(sh_q), .hit(hit), .region(hit_rg));

  logic              go, go_we;
  logic [ADDR_W-1:0] go_addr;
  logic [7:0]        go_wdata, dma_rd;

  edid_dma #(.AW(ADDR_W), .DW(8)) u_dma (
    .clk(clk), .rst_n(rst_n_s), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_wdata(go_wdata), .rd_data(dma_rd), .cpu_stall(cpu_stall),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0]       byte_in;
  logic [OFF_W-1:0] off_cur, off_nxt, off_hit;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; tx_d = tx_q; off_d = off_q;
    rg_d = rg_q; rw_d = rw_q; fw_d = fw_q; oe_d = oe_q;
    go = 1'b0; go_we = 1'b0; go_addr = '0; go_wdata = '0;
    byte_in = {sh_q, sda_s};
    off_cur = off_q & off_mask(rg_q);
    off_nxt = (off_cur + 8'd1) & off_mask(rg_q);
    off_hit = off_q & off_mask(hit_rg);

    if (!en) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = byte_in[6:0];
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              if (!hit) begin
                st_d = ST_SKIP;
              end else begin
                rg_d = hit_rg;
                rw_d = byte_in[0];
                fw_d = ~byte_in[0];
                if (byte_in[0]) begin
                  go      = 1'b1;
                  go_addr = {hit_rg, off_hit};
                  off_d   = (off_hit + 8'd1) & off_mask(hit_rg);
                end
              end
            end
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_d  = ST_AACK;
            oe_d  = 1'b1;
            cnt_d = 4'd0;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_d  = ST_TX;
              oe_d  = ~dma_rd[7];
              tx_d  = dma_rd[6:0];
              cnt_d = 4'd1;
            end else begin
              st_d  = ST_RX;
              oe_d  = 1'b0;
              cnt_d = 4'd0;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = byte_in[6:0];
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              if (fw_q) begin
                off_d = byte_in & off_mask(rg_q);
                fw_d  = 1'b0;
              end else begin
                go       = 1'b1;
                go_we    = 1'b1;
                go_addr  = {rg_q, off_cur};
                go_wdata = byte_in;
                off_d    = off_nxt;
              end
            end
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_d  = ST_RACK;
            oe_d  = 1'b1;
            cnt_d = 4'd0;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            st_d = ST_RX;
            oe_d = 1'b0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_d  = ST_MACK;
              oe_d  = 1'b0;
              cnt_d = 4'd0;
            end else begin
              oe_d  = ~tx_q[6];
              tx_d  = {tx_q[5:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              st_d = ST_SKIP;
              oe_d = 1'b0;
            end else begin
              go      = 1'b1;
              go_addr = {rg_q, off_cur};
              off_d   = off_nxt;
            end
          end else if (scl_fall) begin
            st_d  = ST_TX;
            oe_d  = ~dma_rd[7];
            tx_d  = dma_rd[6:0];
            cnt_d = 4'd1;
          end
        end
        default: oe_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      tx_q  <= '0;
      off_q <= '0;
      rg_q  <= RG_V1;
      rw_q  <= 1'b0;
      fw_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
      off_q <= off_d;
      rg_q  <= rg_d;
      rw_q  <= rw_d;
      fw_q  <= fw_d;
      oe_q  <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/edid_i2c_slave_chk.sv
module edid_i2c_slave_chk #(
  parameter int AW    = 10,
  parameter int OFF_W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sda_oe,
  input logic          cpu_stall,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    cfg_q,
  input logic          in_skip
);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |=> cpu_stall);

  p_stall_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && $past(cpu_stall)) |=> !cpu_stall);

  p_issue_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $rose(cpu_stall));

  p_region_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[AW-1:AW-2] != 2'b11));

  p_small_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_addr[AW-1:AW-2] == 2'b00) |-> !mem_addr[OFF_W-1]);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(cfg_q));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !sda_oe);

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_skip) |-> !sda_oe);
endmodule

bind edid_i2c_slave edid_i2c_slave_chk #(.AW(edid_pkg::ADDR_W), .OFF_W(edid_pkg::OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .en(en), .sda_oe(sda_oe), .cpu_stall(cpu_stall),
  .mem_en(mem_en), .mem_addr(mem_addr), .cfg_q(cfg_q),
  .in_skip(st_q == edid_pkg::ST_SKIP)
);

// File: tb/tb_edid_i2c_slave.sv
module tb_edid_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] cfg = 3'b000;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe, cpu_stall, mem_en, mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  edid_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cpu_stall(cpu_stall), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] bmem [1024];
  logic [7:0] ref_mem [1024];
  int qa[$], qw[$], qd[$];
  int n_chk = 0, n_fail = 0;
  int ref_off = 0, ref_cfg = 0, run = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = 8'((i * 7 + 3) & 255);
      ref_mem[i] = 8'((i * 7 + 3) & 255);
    end
  end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_stall) run++;
      else if (run != 0) begin
        check(run == 2, "R6", "stall run length", run, 2);
        run = 0;
      end
      if (mem_en) begin
        if (qa.size() == 0) begin
          check(0, "R3", "unexpected memory access", int'(mem_addr), -1);
        end else begin
          int a, w, d;
          a = qa.pop_front(); w = qw.pop_front(); d = qd.pop_front();
          check(int'(mem_addr) == a && int'(mem_we) == w && (w == 0 || int'(mem_wdata) == d),
                (w != 0) ? "R3" : "R4", "memory access addr",
                int'(mem_addr), a);
        end
      end
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit ref_acc(input int c, input int dev);
    case (c)
      0, 4: return dev == 'h50;
      1:    return dev == 'h51;
      2, 6: return dev == 'h50 || dev == 'h51;
      3:    return dev == 'h53;
      default: return 0;
    endcase
  endfunction

  function automatic int rix(input int dev);
    return (dev == 'h50) ? 0 : (dev == 'h51) ? 1 : 2;
  endfunction

  function automatic int rsz(input int dev);
    return (dev == 'h50) ? 128 : 256;
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(2*Q);
    sda_m = 1'b0; w(2*Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(2*Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q);
      scl_m = 1'b1; w(2*Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    ack = ~sda_line; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q);
      scl_m = 1'b1; w(Q);
      b = {b[6:0], sda_line}; w(Q);
      scl_m = 1'b0;
    end
    w(Q);
    sda_m = ~give_ack; w(Q);
    scl_m = 1'b1; w(2*Q);
    scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  task automatic probe(input int dev, input string tag);
    bit ack, exp;
    exp = ref_acc(ref_cfg, dev) && en;
    i2c_start();
    send_byte(8'({dev[6:0], 1'b0}), ack);
    check(ack == exp, tag, "address acknowledge", int'(ack), int'(exp));
    if (!exp) begin
      send_byte(8'h00, ack);
      check(ack == 1'b0, "R2", "SDA released after rejected address", int'(ack), 0);
    end
    i2c_stop();
  endtask

  task automatic do_write(input int dev, input int off, input int n, input int seed, input string tag);
    bit ack;
    int rg, sz;
    rg = rix(dev); sz = rsz(dev);
    i2c_start();
    send_byte(8'({dev[6:0], 1'b0}), ack);
    check(ack == 1'b1, tag, "write address acknowledge", int'(ack), 1);
    ref_off = off & (sz - 1);
    send_byte(8'(off), ack);
    check(ack == 1'b1, "R3", "offset byte acknowledge", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      int d, a;
      d = (seed + k * 37) & 255;
      a = rg * 256 + ref_off;
      qa.push_back(a); qw.push_back(1); qd.push_back(d);
      ref_mem[a] = 8'(d);
      ref_off = (ref_off + 1) % sz;
      send_byte(8'(d), ack);
      check(ack == 1'b1, "R3", "data byte acknowledge", int'(ack), 1);
    end
    i2c_stop();
  endtask

  task automatic do_read(input int dev, input int n, input int set_off, input string tag, input bit extra);
    bit ack;
    int rg, sz;
    logic [7:0] b;
    rg = rix(dev); sz = rsz(dev);
    i2c_start();
    if (set_off >= 0) begin
      send_byte(8'({dev[6:0], 1'b0}), ack);
      check(ack == 1'b1, "R8", "write address before restart", int'(ack), 1);
      send_byte(8'(set_off), ack);
      check(ack == 1'b1, "R8", "offset before restart", int'(ack), 1);
      ref_off = set_off & (sz - 1);
      i2c_start();
    end
    ref_off = ref_off & (sz - 1);
    for (int k = 0; k < n; k++) begin
      qa.push_back(rg * 256 + ((ref_off + k) % sz)); qw.push_back(0); qd.push_back(0);
    end
    send_byte(8'({dev[6:0], 1'b1}), ack);
    check(ack == 1'b1, tag, "read address acknowledge", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      int e;
      e = int'(ref_mem[rg * 256 + ref_off]);
      read_byte(k != n - 1, b);
      check(int'(b) == e, tag, "read data", int'(b), e);
      ref_off = (ref_off + 1) % sz;
    end
    if (extra) begin
      read_byte(1'b0, b);
      check(b == 8'hFF, "R7", "bus released after NACK", int'(b), 255);
    end
    i2c_stop();
  endtask

  task automatic set_cfg(input int c);
    en = 1'b0; w(4);
    cfg = 3'(c); w(4);
    en = 1'b1; w(4);
    ref_cfg = c;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    w(5);
    rst_n = 1'b1;
    w(5);
    check(sda_oe == 1'b0, "R10", "reset sda_oe", int'(sda_oe), 0);
    check(cpu_stall == 1'b0, "R6", "reset cpu_stall", int'(cpu_stall), 0);
    check(mem_en == 1'b0, "R6", "reset mem_en", int'(mem_en), 0);

    set_cfg(0);
    do_write('h50, 5, 3, 'h40, "R1");
    do_read('h50, 3, 5, "R8", 1'b0);
    do_read('h50, 2, -1, "R4", 1'b0);
    probe('h51, "R1");
    probe('h53, "R1");

    do_write('h50, 126, 4, 'h90, "R5");
    do_read('h50, 4, 126, "R5", 1'b0);
    do_write('h50, 'h85, 1, 'h11, "R5");
    do_read('h50, 1, 'h85, "R5", 1'b0);

    cfg = 3'b001;
    w(10);
    do_write('h50, 20, 2, 'h22, "R9");
    probe('h51, "R9");

    set_cfg(1);
    probe('h50, "R1");
    do_write('h51, 254, 3, 'h33, "R5");
    do_read('h51, 3, 254, "R11", 1'b0);

    set_cfg(3);
    probe('h50, "R1");
    probe('h51, "R1");
    do_write('h53, 10, 2, 'h5A, "R1");
    do_read('h53, 2, 10, "R11", 1'b0);

    set_cfg(2);
    do_write('h50, 40, 2, 'h66, "R1");
    do_write('h51, 40, 2, 'h77, "R1");
    do_read('h50, 2, 40, "R11", 1'b0);
    do_read('h51, 2, 40, "R11", 1'b0);
    probe('h53, "R1");

    set_cfg(6);
    probe('h50, "R1");
    probe('h51, "R1");
    set_cfg(5);
    probe('h50, "R1");
    probe('h51, "R1");
    probe('h53, "R1");
    set_cfg(7);
    probe('h50, "R1");
    set_cfg(4);
    probe('h50, "R1");
    probe('h51, "R1");

    set_cfg(0);
    do_read('h50, 2, 60, "R7", 1'b1);

    en = 1'b0;
    w(4);
    probe('h50, "R10");
    en = 1'b1;
    w(4);
    probe('h50, "R1");

    w(20);
    check(qa.size() == 0, "R4", "pending expected accesses", qa.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule